// File: doc/BRIEF.md
# User-Space Word Load Unit

This unit decodes and executes a privileged load instruction that reads a 32-bit word through the user-mode view of memory while the processor runs in kernel mode. It takes a 32-bit compact-encoded instruction and the value of its base register. It adds the signed 9-bit displacement to form the effective address, then checks the enables, the segment access mode and the alignment. When every check passes, it sends one doubleword read to a simple memory port. Address translation sits outside the block. The unit drives a flag on the request that asks the translator to use the user-mode mapping.

When the read returns, the unit selects the addressed 32-bit lane of the 64-bit data, sign-extends it to 64 bits and presents it with the destination register index for one cycle. A faulting instruction instead produces a one-cycle exception report carrying a single code, the one with the highest priority. Instructions that do not match the encoding pass through with no effect.

Top module: `uspace_load_unit`

## Requirements
- R1: An instruction matches only when bits [31:26]=011000, [15:12]=0110 and [11:9]=111. Bits [25:21] are the destination index, bits [20:16] name the base register and bits [8:0] are a signed displacement. A non-matching word with `instValid` high produces no request, no result and no exception.
- R2: The effective address is `baseValue` plus the sign-extended displacement. The request address equals that address except bit 2, which is XORed with `reverseEndian`. Bits [1:0] are zero.
- R3: If either of the two low effective-address bits is set, the unit reports exception code 3 and issues no memory request.
- R4: Segment modes 1, 2 and 3 permit the load. Every other `segMode` value reports exception code 3.
- R5: `memReqUserMap` is high during a request exactly when the captured segment mode is 3.
- R6: When `featureEn` is low, exception code 1 is reported, whatever the other checks give.
- R7: When `featureEn` is high and `cp0Usable` is low, exception code 2 is reported. This takes priority over code 3.
- R8: The result lane is the upper half of `memRspData` when effective-address bit 2 XOR `bigEndianCpu` is 1, and the lower half otherwise. The lane is sign-extended to 64 bits.
- R9: A response with `memRspErr` high reports exception code 4 and produces no result.
- R10: `memReqValid` rises the cycle after a clean instruction is accepted. It and its address stay unchanged until `memReqReady` is seen. `busy` holds until the response, and `instValid` is ignored while busy.
- R11: `resValid` pulses for one cycle, the cycle after the response is sampled, with `resRt` and `resData`. `excValid` pulses for one cycle, and never together with `resValid`. Check exceptions appear the cycle after the instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Instruction word offered this cycle |
| instWord | input | 32 | Instruction encoding |
| baseValue | input | 64 | Value of the base register |
| featureEn | input | 1 | Instruction implemented/enabled |
| cp0Usable | input | 1 | System coprocessor access allowed |
| segMode | input | 3 | Access mode of the addressed segment |
| reverseEndian | input | 1 | Reverse-endian mode for the request address |
| bigEndianCpu | input | 1 | Processor runs big-endian |
| memReqValid | output | 1 | Read request valid |
| memReqReady | input | 1 | Memory accepts request |
| memReqAddr | output | 64 | Doubleword request address with swizzled low bits |
| memReqUserMap | output | 1 | Translate with the user-mode mapping |
| memRspValid | input | 1 | Read data returned |
| memRspData | input | 64 | Returned doubleword |
| memRspErr | input | 1 | Bus error on the response |
| busy | output | 1 | Load in flight |
| resValid | output | 1 | Result pulse |
| resRt | output | 5 | Destination register index |
| resData | output | 64 | Sign-extended loaded word |
| excValid | output | 1 | Exception pulse |
| excCode | output | 3 | 1 reserved instruction, 2 coprocessor unusable, 3 address error, 4 bus error |

## Verification
The assertions assume the memory never returns a response before it has accepted a request, and that `memReqReady` matters only while a request is pending. The bench acts as that memory. It answers only after the handshake, optionally after a delay, and raises ready only while a request is visible. The assertions also assume that a new instruction is presented only while the unit is idle, unless the stimulus is testing that it is ignored. The bench offers extra instructions only while a load is in flight, and checks afterwards that no second request follows.

// File: rtl/uload_pkg.sv
package uload_pkg;
  localparam logic [5:0] MAJOR_OP = 6'b011000;
  localparam logic [3:0] GROUP_OP = 4'b0110;
  localparam logic [2:0] MINOR_OP = 3'b111;

  localparam logic [2:0] SEG_KUSER   = 3'd1;
  localparam logic [2:0] SEG_KMAPPED = 3'd2;
  localparam logic [2:0] SEG_USERMAP = 3'd3;

  typedef enum logic [2:0] {
    EXC_NONE = 3'd0,
    EXC_RI   = 3'd1,
    EXC_CPU  = 3'd2,
    EXC_ADDR = 3'd3,
    EXC_BUS  = 3'd4
  } exc_e;

  typedef struct packed {
    logic accept;
    logic takeRsp;
  } ctl_t;
endpackage

// File: rtl/uload_datapath.sv
module uload_datapath
  import uload_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  logic [31:0]       instWord,
  input  logic [ADDR_W-1:0] baseValue,
  input  logic              featureEn,
  input  logic              cp0Usable,
  input  logic [2:0]        segMode,
  input  logic              reverseEndian,
  input  logic              bigEndianCpu,
  input  logic [DATA_W-1:0] memRspData,
  output logic              instMatch,
  output exc_e              chkCode,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic              memReqUserMap,
  output logic [4:0]        resRt,
  output logic [DATA_W-1:0] resData
);
  localparam int OFF_W  = 9;
  localparam int HALF_W = DATA_W / 2;

  logic [ADDR_W-1:0] offsetExt;
  logic [ADDR_W-1:0] effAddr;
  logic              modeOk;

  logic [ADDR_W-1:3] addrHiQ;
  logic              physLaneQ;
  logic              dataLaneHiQ;
  logic              userMapQ;
  logic [4:0]        rtQ;
  logic [DATA_W-1:0] resDataQ;
  logic [HALF_W-1:0] laneWord;

  always_comb begin
    instMatch = (instWord[31:26] == MAJOR_OP) && (instWord[15:12] == GROUP_OP) &&
                (instWord[11:9] == MINOR_OP);
    offsetExt = {{(ADDR_W-OFF_W){instWord[OFF_W-1]}}, instWord[OFF_W-1:0]};
    effAddr   = baseValue + offsetExt;
    modeOk    = (segMode == SEG_KUSER) || (segMode == SEG_KMAPPED) || (segMode == SEG_USERMAP);
    if (!featureEn)                          chkCode = EXC_RI;
    else if (!cp0Usable)                     chkCode = EXC_CPU;
    else if ((effAddr[1:0] != 2'b00) || !modeOk) chkCode = EXC_ADDR;
    else                                     chkCode = EXC_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrHiQ     <= '0;
      physLaneQ   <= 1'b0;
      dataLaneHiQ <= 1'b0;
      userMapQ    <= 1'b0;
      rtQ         <= '0;
    end else if (ctl.accept) begin
      addrHiQ     <= effAddr[ADDR_W-1:3];
      physLaneQ   <= effAddr[2] ^ reverseEndian;
      dataLaneHiQ <= effAddr[2] ^ bigEndianCpu;
      userMapQ    <= (segMode == SEG_USERMAP);
      rtQ         <= instWord[25:21];
    end
  end

  assign laneWord = dataLaneHiQ ? memRspData[DATA_W-1:HALF_W] : memRspData[HALF_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN)            resDataQ <= '0;
    else if (ctl.takeRsp) resDataQ <= {{(DATA_W-HALF_W){laneWord[HALF_W-1]}}, laneWord};
  end

  assign memReqAddr    = {addrHiQ, physLaneQ, 2'b00};
  assign memReqUserMap = userMapQ;
  assign resRt         = rtQ;
  assign resData       = resDataQ;

  // R3
  accept_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.accept |-> (chkCode == EXC_NONE && instMatch));

  // R1
  accept_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.accept |-> (instWord[31:26] == MAJOR_OP));
endmodule

// File: rtl/uload_ctrl.sv
module uload_ctrl
  import uload_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instValid,
  input  logic       instMatch,
  input  exc_e       chkCode,
  input  logic       memReqReady,
  input  logic       memRspValid,
  input  logic       memRspErr,
  output ctl_t       ctl,
  output logic       busy,
  output logic       memReqValid,
  output logic       resValid,
  output logic       excValid,
  output logic [2:0] excCode
);
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} state_e;
  state_e state;
  logic   takeInst;

  always_comb begin
    takeInst    = (state == ST_IDLE) && instValid && instMatch;
    ctl.accept  = takeInst && (chkCode == EXC_NONE);
    ctl.takeRsp = (state == ST_WAIT) && memRspValid && !memRspErr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      resValid <= 1'b0;
      excValid <= 1'b0;
      excCode  <= EXC_NONE;
    end else begin
      resValid <= 1'b0;
      excValid <= 1'b0;
      unique case (state)
        ST_IDLE: if (takeInst) begin
          if (chkCode == EXC_NONE) state <= ST_REQ;
          else begin
            excValid <= 1'b1;
            excCode  <= chkCode;
          end
        end
        ST_REQ: if (memReqReady) state <= ST_WAIT;
        ST_WAIT: if (memRspValid) begin
          state <= ST_IDLE;
          if (memRspErr) begin
            excValid <= 1'b1;
            excCode  <= EXC_BUS;
          end else begin
            resValid <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (state != ST_IDLE);
  assign memReqValid = (state == ST_REQ);

  // R11
  res_exc_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(resValid && excValid));

  // R11
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> memReqValid);
endmodule

// File: rtl/uspace_load_unit.sv
module uspace_load_unit
  import uload_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [31:0]       instWord,
  input  logic [ADDR_W-1:0] baseValue,
  input  logic              featureEn,
  input  logic              cp0Usable,
  input  logic [2:0]        segMode,
  input  logic              reverseEndian,
  input  logic              bigEndianCpu,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic              memReqUserMap,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRspData,
  input  logic              memRspErr,
  output logic              busy,
  output logic              resValid,
  output logic [4:0]        resRt,
  output logic [DATA_W-1:0] resData,
  output logic              excValid,
  output logic [2:0]        excCode
);
  ctl_t ctl;
  logic instMatch;
  exc_e chkCode;

  uload_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .instWord(instWord), .baseValue(baseValue),
    .featureEn(featureEn), .cp0Usable(cp0Usable), .segMode(segMode),
    .reverseEndian(reverseEndian), .bigEndianCpu(bigEndianCpu), .memRspData(memRspData),
    .instMatch(instMatch), .chkCode(chkCode), .memReqAddr(memReqAddr),
    .memReqUserMap(memReqUserMap), .resRt(resRt), .resData(resData)
  );

  uload_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instMatch(instMatch), .chkCode(chkCode),
    .memReqReady(memReqReady), .memRspValid(memRspValid), .memRspErr(memRspErr),
    .ctl(ctl), .busy(busy), .memReqValid(memReqValid), .resValid(resValid),
    .excValid(excValid), .excCode(excCode)
  );

  // R10
  req_addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> $stable(memReqAddr));

  // R11
  res_after_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $past(memRspValid && !memRspErr));
endmodule

// File: tb/test_uspace_load_unit.sv
`timescale 1ns/1ps
module test_uspace_load_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [31:0] instWord = '0;
  logic [63:0] baseValue = '0;
  logic        featureEn = 1'b0, cp0Usable = 1'b0;
  logic [2:0]  segMode = '0;
  logic        reverseEndian = 1'b0, bigEndianCpu = 1'b0;
  logic        memReqValid, memReqReady = 1'b0;
  logic [63:0] memReqAddr;
  logic        memReqUserMap;
  logic        memRspValid = 1'b0;
  logic [63:0] memRspData = '0;
  logic        memRspErr = 1'b0;
  logic        busy, resValid, excValid;
  logic [4:0]  resRt;
  logic [63:0] resData;
  logic [2:0]  excCode;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  uspace_load_unit i_uspace_load_unit (.*);

  function automatic logic [31:0] mkInst(input logic [4:0] rt, input logic [4:0] bs, input logic [8:0] off);
    return {6'b011000, rt, bs, 4'b0110, 3'b111, off};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runLoad(input logic [31:0] w, input logic [63:0] b, input logic fe, input logic cp,
                         input logic [2:0] md, input logic rv, input logic bg,
                         input int rdyDly, input int rspDly, input logic err);
    logic [63:0] ea, expAddr, data, expRes;
    logic [2:0]  expCode;
    logic [31:0] lane;
    ea = b + {{55{w[8]}}, w[8:0]};
    if (!fe)                                       expCode = 3'd1;
    else if (!cp)                                  expCode = 3'd2;
    else if (ea[1:0] != 0 || md == 0 || md > 3)    expCode = 3'd3;
    else                                           expCode = 3'd0;
    @(negedge clk);
    instWord = w; baseValue = b; featureEn = fe; cp0Usable = cp; segMode = md;
    reverseEndian = rv; bigEndianCpu = bg; instValid = 1'b1;
    @(negedge clk);
    instValid = 1'b0;
    if (expCode != 0) begin
      chk(excValid && excCode == expCode, "R3/R4/R6/R7 exc code", {61'd0, excCode}, {61'd0, expCode});
      chk(!memReqValid && !busy && !resValid, "R3 no request", {62'd0, memReqValid, busy}, 64'd0);
      @(negedge clk);
      chk(!excValid && !memReqValid, "R11 exc pulse one cycle", {63'd0, excValid}, 64'd0);
      return;
    end
    expAddr = {ea[63:3], ea[2] ^ rv, 2'b00};
    chk(memReqValid && !excValid && busy, "R10 request raised", {63'd0, memReqValid}, 64'd1);
    chk(memReqAddr == expAddr, "R2 request address", memReqAddr, expAddr);
    chk(memReqUserMap == (md == 3'd3), "R5 user map flag", {63'd0, memReqUserMap}, {63'd0, md == 3'd3});
    for (int i = 0; i < rdyDly; i++) begin
      @(negedge clk);
      chk(memReqValid && memReqAddr == expAddr, "R10 request held", memReqAddr, expAddr);
    end
    memReqReady = 1'b1;
    @(negedge clk);
    memReqReady = 1'b0;
    chk(!memReqValid && busy, "R10 busy after handshake", {62'd0, memReqValid, busy}, 64'd1);
    instWord = mkInst(5'd7, 5'd3, 9'd0); instValid = 1'b1; featureEn = 1'b1; cp0Usable = 1'b1;
    segMode = 3'd1;
    for (int i = 0; i < rspDly; i++) @(negedge clk);
    data = {ea[31:0] ^ 32'h9abc_def0, ~ea[31:0]};
    memRspValid = 1'b1; memRspData = data; memRspErr = err;
    @(negedge clk);
    memRspValid = 1'b0; memRspErr = 1'b0; instValid = 1'b0;
    if (err) begin
      chk(excValid && excCode == 3'd4 && !resValid, "R9 bus error", {61'd0, excCode}, 64'd4);
    end else begin
      lane   = (ea[2] ^ bg) ? data[63:32] : data[31:0];
      expRes = {{32{lane[31]}}, lane};
      chk(resValid && !excValid, "R11 result pulse", {63'd0, resValid}, 64'd1);
      chk(resData == expRes, "R8 lane and sign extension", resData, expRes);
      chk(resRt == w[25:21], "R11 destination index", {59'd0, resRt}, {59'd0, w[25:21]});
    end
    @(negedge clk);
    chk(!resValid && !excValid && !busy && !memReqValid, "R10 busy-time instruction ignored",
        {60'd0, resValid, excValid, busy, memReqValid}, 64'd0);
  endtask

  task automatic runNoMatch(input logic [31:0] w);
    @(negedge clk);
    instWord = w; featureEn = 1'b0; cp0Usable = 1'b0; segMode = 3'd0; instValid = 1'b1;
    @(negedge clk);
    instValid = 1'b0;
    chk(!memReqValid && !excValid && !resValid && !busy, "R1 non-matching ignored",
        {60'd0, memReqValid, excValid, resValid, busy}, 64'd0);
  endtask

  initial begin
    #(200000 * 20);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic [8:0]  offs [6];
    logic [63:0] bases [3];
    offs[0] = 9'h000; offs[1] = 9'h004; offs[2] = 9'h0fc;
    offs[3] = 9'h100; offs[4] = 9'h1fc; offs[5] = 9'h10c;
    bases[0] = 64'h0000_0000_0000_1000;
    bases[1] = 64'hffff_ffff_8000_2004;
    bases[2] = 64'h0000_0012_6000_0ff8;
    repeat (3) @(negedge clk);
    chk(!busy && !memReqValid && !resValid && !excValid, "reset state",
        {60'd0, busy, memReqValid, resValid, excValid}, 64'd0);
    rstN = 1'b1;

    // R1: each fixed field corrupted in turn
    runNoMatch(mkInst(5'd1, 5'd2, 9'd4) ^ 32'h0400_0000);
    runNoMatch(mkInst(5'd1, 5'd2, 9'd4) ^ 32'h0000_1000);
    runNoMatch(mkInst(5'd1, 5'd2, 9'd4) ^ 32'h0000_0200);
    runNoMatch(32'h0);

    // R3 R4 R6 R7: sweep of enables, modes and misalignment
    for (int fe = 0; fe < 2; fe++)
      for (int cp = 0; cp < 2; cp++)
        for (int md = 0; md < 8; md++)
          for (int lo = 0; lo < 4; lo++)
            runLoad(mkInst(5'(md + 4 * lo), 5'd9, 9'(lo)), 64'h40, fe[0], cp[0], 3'(md),
                    1'b0, 1'b0, 0, 0, 1'b0);

    // R2 R5 R8 R11: legal loads over endianness, offsets and bases
    for (int e = 0; e < 4; e++)
      for (int o = 0; o < 6; o++)
        for (int b = 0; b < 3; b++)
          runLoad(mkInst(5'(o * 5 + b), 5'd4, offs[o]), bases[b], 1'b1, 1'b1, 3'(1 + (o + b) % 3),
                  e[1], e[0], (o + b) % 3, b % 2, 1'b0);

    // R9: bus errors
    runLoad(mkInst(5'd2, 5'd1, 9'd8), 64'h100, 1'b1, 1'b1, 3'd3, 1'b0, 1'b1, 1, 2, 1'b1);
    runLoad(mkInst(5'd3, 5'd1, 9'h1f8), 64'h100, 1'b1, 1'b1, 3'd2, 1'b1, 1'b0, 0, 0, 1'b1);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule